// File: doc/BRIEF.md
# Timing Pattern Pipeline Assembler

This block sits between the source of machine timing patterns and the event distribution hardware. A 128-bit timing pattern is delivered once per 360 Hz fiducial. Each pattern is announced well before the fiducial on which it must take effect. The block parks every pattern in a short shift pipeline, so a pattern is released three fiducials after it was queued.

While a pattern waits in the pipeline, late machine-protection status can still be applied to it. This status is a rate-limit code and a mitigation-device code, and it can change during the last 1/120 s before execution. When a pattern reaches the head of the pipeline and its fiducial arrives, the block emits it. The emitted frame carries the pattern, a timestamp sampled on that fiducial, the protection fields, and a flag that marks a fiducial for which no pattern was delivered.

Top module: `tpat_assembler`

## Requirements
- R1: While reset is asserted and after its release, `frm_valid` is 0 and every frame output is 0 until the first frame is emitted.
- R2: A pattern queued on a given fiducial is emitted on the third fiducial after that one. The pipeline depth is 3.
- R3: `frm_valid` is high for exactly the one cycle after the clock edge that samples `fid` high, and only when the head entry is occupied. The first three fiducials after reset emit nothing.
- R4: `frm_ts` equals the value of `ts_now` that was sampled on the clock edge that also sampled the emitting fiducial.
- R5: If no pattern was delivered since the previous fiducial, the queued entry holds an all-zero pattern. That frame is emitted with `frm_missing` = 1. Otherwise `frm_missing` = 0.
- R6: A pattern strobed in the same cycle as `fid` is queued on that fiducial.
- R7: If several patterns are strobed between two fiducials, the last one is queued.
- R8: A late update outside a fiducial cycle overwrites `rate` (4-bit code) and `mit` (2-bit code) in every queued entry. Entries queued afterwards carry the updated values until the next update.
- R9: A late update in the same cycle as `fid` leaves the frame emitted on that fiducial with its earlier protection fields. The update still applies to every entry that stays queued and to the entry that enters on that fiducial.
- R10: All frame outputs hold their values between emissions.
- R11: All 128 pattern bits pass through unchanged, including the 4-bit rollover countdown in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_valid | input | 1 | Pattern strobe |
| pat_data | input | 128 | Timing pattern |
| fid | input | 1 | Fiducial pulse, one cycle |
| upd_valid | input | 1 | Late protection update strobe |
| upd_rate | input | 4 | Rate-limit code |
| upd_mit | input | 2 | Mitigation-device code |
| ts_now | input | 64 | Free-running timestamp |
| frm_valid | output | 1 | Frame strobe |
| frm_pattern | output | 128 | Emitted pattern |
| frm_ts | output | 64 | Timestamp sampled on the emitting fiducial |
| frm_rate | output | 4 | Rate-limit code of the frame |
| frm_mit | output | 2 | Mitigation-device code of the frame |
| frm_missing | output | 1 | No pattern was delivered for this slot |

## Verification
Two kinds of event can share one cycle: a late protection update and a fiducial, and a pattern strobe and a fiducial. The bench drives each pair on the same clock edge. For the update case it checks three things: the emitted frame still shows the earlier protection codes, the frames from the following fiducials show the new codes, and that includes the frame whose pattern entered on the colliding fiducial. For the strobe case it checks that the strobed pattern comes out three fiducials later and is not flagged as missing.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
   localparam int RATE_W = 4;
   localparam int MIT_W  = 2;

   typedef struct packed {
      logic [RATE_W-1:0] rate;
      logic [MIT_W-1:0]  mit;
   } prot_t;
endpackage

// File: rtl/tpat_stage.sv
module tpat_stage #(
   parameter int PAT_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pat_valid,
   input  logic [PAT_W-1:0] pat_data,
   input  logic             fid,
   output logic [PAT_W-1:0] tail_pat,
   output logic             tail_missing
);
   logic [PAT_W-1:0] held_q;
   logic             held_full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q      <= '0;
         held_full_q <= 1'b0;
      end else if (fid) begin
         held_full_q <= 1'b0;
      end else if (pat_valid) begin
         held_q      <= pat_data;
         held_full_q <= 1'b1;
      end
   end

   always_comb begin
      if (pat_valid)        tail_pat = pat_data;
      else if (held_full_q) tail_pat = held_q;
      else                  tail_pat = '0;
      tail_missing = !pat_valid && !held_full_q;
   end
endmodule

// File: rtl/tpat_prot_reg.sv
module tpat_prot_reg
   import tpat_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  upd_valid,
   input  prot_t upd_prot,
   output prot_t cur_prot
);
   prot_t cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         cur_q <= '0;
      else if (upd_valid) cur_q <= upd_prot;
   end

   assign cur_prot = cur_q;
endmodule

// File: rtl/tpat_queue.sv
module tpat_queue
   import tpat_pkg::*;
#(
   parameter int PAT_W = 128,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fid,
   input  logic [PAT_W-1:0] tail_pat,
   input  logic             tail_missing,
   input  prot_t            tail_prot,
   input  logic             upd_valid,
   input  prot_t            upd_prot,
   output logic [PAT_W-1:0] head_pat,
   output prot_t            head_prot,
   output logic             head_missing,
   output logic             head_full
);
   localparam int LAST = DEPTH - 1;

   logic [PAT_W-1:0] pat_q  [DEPTH];
   prot_t            prot_q [DEPTH];
   logic             miss_q [DEPTH];
   logic             full_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PAT_W-1:0] nxt_pat;
      prot_t            nxt_prot;
      logic             nxt_miss;
      logic             nxt_full;

      if (i == LAST) begin : g_tail
         always_comb begin
            nxt_pat  = tail_pat;
            nxt_prot = tail_prot;
            nxt_miss = tail_missing;
            nxt_full = 1'b1;
         end
      end else begin : g_mid
         always_comb begin
            nxt_pat  = pat_q[i+1];
            nxt_prot = prot_q[i+1];
            nxt_miss = miss_q[i+1];
            nxt_full = full_q[i+1];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pat_q[i]  <= '0;
            prot_q[i] <= '0;
            miss_q[i] <= 1'b0;
            full_q[i] <= 1'b0;
         end else if (fid) begin
            pat_q[i]  <= nxt_pat;
            prot_q[i] <= upd_valid ? upd_prot : nxt_prot;
            miss_q[i] <= nxt_miss;
            full_q[i] <= nxt_full;
         end else if (upd_valid) begin
            prot_q[i] <= upd_prot;
         end
      end
   end

   assign head_pat     = pat_q[0];
   assign head_prot    = prot_q[0];
   assign head_missing = miss_q[0];
   assign head_full    = full_q[0];
endmodule

// File: rtl/tpat_emit.sv
module tpat_emit
   import tpat_pkg::*;
#(
   parameter int PAT_W = 128,
   parameter int TS_W  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fid,
   input  logic [TS_W-1:0]  ts_now,
   input  logic [PAT_W-1:0] head_pat,
   input  prot_t            head_prot,
   input  logic             head_missing,
   input  logic             head_full,
   output logic             frm_valid,
   output logic [PAT_W-1:0] frm_pattern,
   output logic [TS_W-1:0]  frm_ts,
   output prot_t            frm_prot,
   output logic             frm_missing
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frm_valid   <= 1'b0;
         frm_pattern <= '0;
         frm_ts      <= '0;
         frm_prot    <= '0;
         frm_missing <= 1'b0;
      end else begin
         frm_valid <= fid && head_full;
         if (fid && head_full) begin
            frm_pattern <= head_pat;
            frm_ts      <= ts_now;
            frm_prot    <= head_prot;
            frm_missing <= head_missing;
         end
      end
   end
endmodule

// File: rtl/tpat_assembler.sv
module tpat_assembler
   import tpat_pkg::*;
#(
   parameter int PAT_W = 128,
   parameter int DEPTH = 3,
   parameter int TS_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pat_valid,
   input  logic [PAT_W-1:0]  pat_data,
   input  logic              fid,
   input  logic              upd_valid,
   input  logic [RATE_W-1:0] upd_rate,
   input  logic [MIT_W-1:0]  upd_mit,
   input  logic [TS_W-1:0]   ts_now,
   output logic              frm_valid,
   output logic [PAT_W-1:0]  frm_pattern,
   output logic [TS_W-1:0]   frm_ts,
   output logic [RATE_W-1:0] frm_rate,
   output logic [MIT_W-1:0]  frm_mit,
   output logic              frm_missing
);
   if (DEPTH < 1 || DEPTH > 16) begin : g_bad_depth
      $error("tpat_assembler: DEPTH out of range");
   end
   if (PAT_W < 4) begin : g_bad_pat
      $error("tpat_assembler: PAT_W must hold the rollover countdown");
   end
   if (TS_W < 1) begin : g_bad_ts
      $error("tpat_assembler: TS_W must be positive");
   end

   prot_t            upd_prot, cur_prot, head_prot, frm_prot;
   logic [PAT_W-1:0] tail_pat, head_pat;
   logic             tail_missing, head_missing, head_full;

   assign upd_prot = '{rate: upd_rate, mit: upd_mit};

   tpat_stage #(.PAT_W(PAT_W)) stage_i (
      .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_data(pat_data),
      .fid(fid), .tail_pat(tail_pat), .tail_missing(tail_missing)
   );

   tpat_prot_reg prot_i (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_prot(upd_prot),
      .cur_prot(cur_prot)
   );

   tpat_queue #(.PAT_W(PAT_W), .DEPTH(DEPTH)) queue_i (
      .clk(clk), .rst_n(rst_n), .fid(fid),
      .tail_pat(tail_pat), .tail_missing(tail_missing), .tail_prot(cur_prot),
      .upd_valid(upd_valid), .upd_prot(upd_prot),
      .head_pat(head_pat), .head_prot(head_prot),
      .head_missing(head_missing), .head_full(head_full)
   );

   tpat_emit #(.PAT_W(PAT_W), .TS_W(TS_W)) emit_i (
      .clk(clk), .rst_n(rst_n), .fid(fid), .ts_now(ts_now),
      .head_pat(head_pat), .head_prot(head_prot),
      .head_missing(head_missing), .head_full(head_full),
      .frm_valid(frm_valid), .frm_pattern(frm_pattern), .frm_ts(frm_ts),
      .frm_prot(frm_prot), .frm_missing(frm_missing)
   );

   assign frm_rate = frm_prot.rate;
   assign frm_mit  = frm_prot.mit;
endmodule

// File: rtl/tpat_assembler_chk.sv
module tpat_assembler_chk #(
   parameter int PAT_W = 128,
   parameter int DEPTH = 3,
   parameter int TS_W  = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fid,
   input logic [TS_W-1:0]  ts_now,
   input logic             frm_valid,
   input logic [PAT_W-1:0] frm_pattern,
   input logic [TS_W-1:0]  frm_ts,
   input logic [3:0]       frm_rate,
   input logic [1:0]       frm_mit,
   input logic             frm_missing
);
   logic [4:0] fid_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                     fid_cnt <= '0;
      else if (fid && fid_cnt < 5'd31) fid_cnt <= fid_cnt + 5'd1;
   end

   a_r3_valid_follows_fid: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> $past(fid));

   a_r3_no_early_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (fid_cnt <= 5'(DEPTH)) |-> !frm_valid);

   a_r4_ts_sampled: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> (frm_ts == $past(ts_now)));

   a_r5_missing_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_missing) |-> (frm_pattern == '0));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |-> ($stable(frm_pattern) && $stable(frm_ts) &&
                      $stable(frm_rate) && $stable(frm_mit) && $stable(frm_missing)));
endmodule

bind tpat_assembler tpat_assembler_chk #(.PAT_W(PAT_W), .DEPTH(DEPTH), .TS_W(TS_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .fid(fid), .ts_now(ts_now),
   .frm_valid(frm_valid), .frm_pattern(frm_pattern), .frm_ts(frm_ts),
   .frm_rate(frm_rate), .frm_mit(frm_mit), .frm_missing(frm_missing)
);

// File: tb/tpat_assembler_tb_top.sv
module tpat_assembler_tb_top;
   localparam int PW = 128;
   localparam int TW = 64;
   localparam int D  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pat_valid = 1'b0;
   logic [PW-1:0] pat_data = '0;
   logic          fid = 1'b0;
   logic          upd_valid = 1'b0;
   logic [3:0]    upd_rate = '0;
   logic [1:0]    upd_mit = '0;
   logic [TW-1:0] ts_now = '0;
   logic          frm_valid;
   logic [PW-1:0] frm_pattern;
   logic [TW-1:0] frm_ts;
   logic [3:0]    frm_rate;
   logic [1:0]    frm_mit;
   logic          frm_missing;

   int n_chk = 0;
   int n_bad = 0;

   // expectation model built from the requirements
   logic [PW-1:0] m_pat  [D];
   logic [3:0]    m_rate [D];
   logic [1:0]    m_mit  [D];
   logic          m_miss [D];
   logic          m_full [D];
   logic [PW-1:0] m_stage = '0;
   logic          m_stage_full = 1'b0;
   logic [3:0]    m_cur_rate = '0;
   logic [1:0]    m_cur_mit = '0;

   always #10 clk = ~clk;

   tpat_assembler dut_i (
      .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_data(pat_data),
      .fid(fid), .upd_valid(upd_valid), .upd_rate(upd_rate), .upd_mit(upd_mit),
      .ts_now(ts_now), .frm_valid(frm_valid), .frm_pattern(frm_pattern),
      .frm_ts(frm_ts), .frm_rate(frm_rate), .frm_mit(frm_mit),
      .frm_missing(frm_missing)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send_pat(input logic [PW-1:0] p);
      @(negedge clk);
      pat_valid = 1'b1; pat_data = p;
      @(negedge clk);
      pat_valid = 1'b0;
      m_stage = p; m_stage_full = 1'b1;
   endtask

   task automatic send_upd(input logic [3:0] r, input logic [1:0] m);
      @(negedge clk);
      upd_valid = 1'b1; upd_rate = r; upd_mit = m;
      @(negedge clk);
      upd_valid = 1'b0;
      m_cur_rate = r; m_cur_mit = m;
      for (int i = 0; i < D; i++) begin m_rate[i] = r; m_mit[i] = m; end
   endtask

   task automatic do_fid(input bit wp, input logic [PW-1:0] p, input bit wu,
                         input logic [3:0] r, input logic [1:0] m, input string req);
      logic [PW-1:0] e_pat; logic [3:0] e_rate; logic [1:0] e_mit;
      logic e_miss, e_full; logic [TW-1:0] e_ts;
      @(negedge clk);
      fid = 1'b1; ts_now = ts_now + 64'd1001;
      pat_valid = wp; pat_data = p;
      upd_valid = wu; upd_rate = r; upd_mit = m;
      e_ts = ts_now;
      e_pat = m_pat[0]; e_rate = m_rate[0]; e_mit = m_mit[0];
      e_miss = m_miss[0]; e_full = m_full[0];
      for (int i = 0; i < D-1; i++) begin
         m_pat[i] = m_pat[i+1]; m_rate[i] = m_rate[i+1]; m_mit[i] = m_mit[i+1];
         m_miss[i] = m_miss[i+1]; m_full[i] = m_full[i+1];
      end
      m_pat[D-1]  = wp ? p : (m_stage_full ? m_stage : '0);
      m_miss[D-1] = !wp && !m_stage_full;
      m_full[D-1] = 1'b1;
      m_rate[D-1] = m_cur_rate; m_mit[D-1] = m_cur_mit;
      m_stage_full = 1'b0;
      if (wu) begin
         m_cur_rate = r; m_cur_mit = m;
         for (int i = 0; i < D; i++) begin m_rate[i] = r; m_mit[i] = m; end
      end
      @(negedge clk);
      fid = 1'b0; pat_valid = 1'b0; upd_valid = 1'b0;
      chk(frm_valid == e_full, req, "frm_valid", PW'(frm_valid), PW'(e_full));
      if (e_full) begin
         chk(frm_pattern == e_pat, req, "pattern", frm_pattern, e_pat);
         chk(frm_ts == e_ts, "R4", "timestamp", PW'(frm_ts), PW'(e_ts));
         chk(frm_rate == e_rate, req, "rate", PW'(frm_rate), PW'(e_rate));
         chk(frm_mit == e_mit, req, "mit", PW'(frm_mit), PW'(e_mit));
         chk(frm_missing == e_miss, req, "missing", PW'(frm_missing), PW'(e_miss));
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      for (int i = 0; i < D; i++) begin
         m_pat[i] = '0; m_rate[i] = '0; m_mit[i] = '0; m_miss[i] = 1'b0; m_full[i] = 1'b0;
      end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(frm_valid == 1'b0, "R1", "valid in reset", PW'(frm_valid), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frm_valid == 1'b0 && frm_pattern == '0 && frm_ts == '0 && !frm_missing,
          "R1", "outputs after reset", frm_pattern, '0);
   endtask

   task automatic t_fill;   // R3: nothing emitted while pipeline fills
      for (int k = 0; k < D; k++) begin
         send_pat({32'hA000_0000 + 32'(k), 92'h0, 4'(k)});
         do_fid(1'b0, '0, 1'b0, '0, '0, "R3");
      end
   endtask

   task automatic t_stream;  // R2, R11: patterns leave three fiducials later
      for (int k = 0; k < D; k++) begin
         send_pat({32'hB000_0000 + 32'(k), 88'hF0F0_1234_5678_9ABC_DEF0_11, 8'h5A - 8'(k)});
         do_fid(1'b0, '0, 1'b0, '0, '0, k == 0 ? "R2" : "R11");
      end
   endtask

   task automatic t_missing; // R5
      do_fid(1'b0, '0, 1'b0, '0, '0, "R5");
      for (int k = 0; k < D; k++) do_fid(1'b1, {64'hC0, 64'(k)}, 1'b0, '0, '0, "R5");
   endtask

   task automatic t_same_cycle; // R6
      for (int k = 0; k < D + 1; k++) do_fid(1'b1, {96'hD6, 32'(k)}, 1'b0, '0, '0, "R6");
   endtask

   task automatic t_replace; // R7
      for (int k = 0; k < D; k++) begin
         send_pat({64'hE1, 64'(k)});
         send_pat({64'hE7, 64'(k)});
         do_fid(1'b0, '0, 1'b0, '0, '0, "R7");
      end
   endtask

   task automatic t_late_update; // R8
      send_pat({64'hF8, 64'h1});
      send_upd(4'h6, 2'b10);
      do_fid(1'b0, '0, 1'b0, '0, '0, "R8");
      for (int k = 0; k < D; k++) do_fid(1'b1, {64'hF8, 64'(k + 2)}, 1'b0, '0, '0, "R8");
   endtask

   task automatic t_update_on_fid; // R9
      do_fid(1'b1, {64'h99, 64'h0}, 1'b1, 4'h3, 2'b01, "R9");
      for (int k = 0; k < D + 1; k++) do_fid(1'b1, {64'h99, 64'(k + 1)}, 1'b0, '0, '0, "R9");
   endtask

   task automatic t_hold;    // R10
      logic [PW-1:0] p0; logic [TW-1:0] t0;
      do_fid(1'b1, {64'hAB, 64'h10}, 1'b0, '0, '0, "R10");
      p0 = frm_pattern; t0 = frm_ts;
      send_pat({64'hAB, 64'h11});
      send_upd(4'hC, 2'b11);
      repeat (5) @(negedge clk);
      chk(!frm_valid && frm_pattern == p0 && frm_ts == t0, "R10", "hold",
          frm_pattern, p0);
   endtask

   initial begin : watchdog
      #3ms;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_fill();
      t_stream();
      t_missing();
      t_same_cycle();
      t_replace();
      t_late_update();
      t_update_on_fid();
      t_hold();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule